// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits beside a byte-wide non-volatile memory and watches every write cycle that the host presents. It recognises the multi-write unlock sequences used by this class of parts and turns them into simple control outputs. These outputs open a page-load window, start a chip erase, and switch product identification reads on or off. The block also keeps a software write-protect flag that is set from reset. While that flag is set, an ordinary data write reaches the array only inside a load window opened by the three-write unlock. Any other data write is dropped, and a one-cycle rejection pulse reports it.

Sequences share a common two-write prefix: a lead write of AAh to 5555h, then 55h to 2AAAh. The third write decides the branch. A0h opens a load window. F0h leaves identification mode. 80h continues into a second lead/second pair, and the sixth write then selects erase (10h) or identification entry (60h). All command address matching uses the low 15 address bits only. In identification mode, reads of the two lowest addresses return fixed manufacturer and device codes. All other reads pass the array data through.

The page buffer, the program and erase timers and the array itself live outside this block. They see only the forwarded write strobe with its address and data, the erase start pulse and the mode levels.

Top module: `cmd_seq_decoder`

## Requirements
- R1: After reset, prot_en_o is 1, and id_mode_o, load_open_o, array_wr_o, write_rejected_o and erase_start_o are all 0.
- R2: Command addresses are compared on wr_addr_i[14:0] only. Writes at 15555h, 0AAAAh and 1D555h therefore act as the 5555h, 2AAAh and 5555h steps.
- R3: The writes AAh@5555h, 55h@2AAAh, A0h@5555h set load_open_o in the cycle after the third write, and prot_en_o stays 1. A write consumed as a command step is never forwarded and never rejected.
- R4: While load_open_o is 1, a write that is not a command step gives array_wr_o=1 in the next cycle, with array_addr_o/array_data_o equal to that write's address and data. Each accepted write restarts the window. The window closes LOAD_TIMEOUT cycles after the last accepted write.
- R5: With prot_en_o=1 and load_open_o=0, a write that is not a command step is not forwarded, and write_rejected_o is 1 for one cycle after it.
- R6: The writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 10h@5555h give a one-cycle erase_start_o pulse in the cycle after the sixth write, and in no other cycle.
- R7: The same five-write prefix followed by 60h@5555h sets id_mode_o to 1 in the cycle after the sixth write.
- R8: While id_mode_o=1, rd_data_o is DAh for rd_addr_i=0 and C1h for rd_addr_i=1. For every other address, and whenever id_mode_o=0, rd_data_o equals array_rd_data_i.
- R9: The writes AAh@5555h, 55h@2AAAh, F0h@5555h clear id_mode_o in the cycle after the third write.
- R10: A write that does not match the expected next step returns the tracker to idle. The same write is then examined as a first step, so AAh@5555h restarts a sequence, and any other write is handled as a data write.
- R11: A third write other than A0h/80h/F0h at 5555h, or a sixth write other than 10h/60h at 5555h, changes no mode and is handled as a data write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_valid_i | input | 1 | One host write cycle this clock |
| wr_addr_i | input | 17 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 17 | Read address |
| array_rd_data_i | input | 8 | Array data for rd_addr_i |
| rd_data_o | output | 8 | Read data to host |
| array_wr_o | output | 1 | Forwarded data write strobe |
| array_addr_o | output | 17 | Forwarded write address |
| array_data_o | output | 8 | Forwarded write data |
| write_rejected_o | output | 1 | Data write blocked by protection |
| erase_start_o | output | 1 | Chip erase start pulse |
| id_mode_o | output | 1 | Product identification mode active |
| prot_en_o | output | 1 | Software write protection enabled |
| load_open_o | output | 1 | Page-load window open |

## Verification
The hardest situations to reach are the ones where a broken sequence overlaps the start of a new one. Examples are a repeated lead write, a stray data write between the second and third steps, or a wrong sixth byte after five correct ones. The stimulus builds these as explicit write lists. Each one is checked at the ports: a restart must still unlock, and a broken sequence must unlock nothing and must raise a rejection. The window timeout is reached by first letting an accepted write restart the window, then idling past LOAD_TIMEOUT cycles before the next write.

// File: rtl/cmd_seq_pkg.sv
package cmd_seq_pkg;
  localparam int CMD_AW = 15;
  localparam logic [CMD_AW-1:0] ADDR_LEAD = 15'h5555;
  localparam logic [CMD_AW-1:0] ADDR_SECOND = 15'h2AAA;

  localparam logic [7:0] BYTE_LEAD = 8'hAA;
  localparam logic [7:0] BYTE_SECOND = 8'h55;
  localparam logic [7:0] BYTE_UNLOCK = 8'hA0;
  localparam logic [7:0] BYTE_EXTEND = 8'h80;
  localparam logic [7:0] BYTE_ERASE = 8'h10;
  localparam logic [7:0] BYTE_ID_ENTER = 8'h60;
  localparam logic [7:0] BYTE_ID_EXIT = 8'hF0;

  typedef enum logic [2:0] {
    ST_IDLE, ST_P1, ST_P2, ST_X3, ST_X4, ST_X5
  } seq_state_e;

  typedef enum logic [2:0] {
    EV_NONE, EV_UNLOCK, EV_ERASE, EV_ID_ENTER, EV_ID_EXIT
  } seq_event_e;
endpackage

// File: rtl/cmd_step_match.sv
module cmd_step_match
  import cmd_seq_pkg::*;
(
  input  logic [CMD_AW-1:0] addr_i,
  input  logic [7:0]        data_i,
  output logic              at_lead_addr_o,
  output logic              is_lead_o,
  output logic              is_second_o
);
  always_comb begin
    at_lead_addr_o = (addr_i == ADDR_LEAD);
    is_lead_o      = at_lead_addr_o && (data_i == BYTE_LEAD);
    is_second_o    = (addr_i == ADDR_SECOND) && (data_i == BYTE_SECOND);
  end
endmodule

// File: rtl/cmd_seq_fsm.sv
module cmd_seq_fsm
  import cmd_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_valid_i,
  input  logic       at_lead_addr_i,
  input  logic       is_lead_i,
  input  logic       is_second_i,
  input  logic [7:0] data_i,
  output logic       consumed_o,
  output seq_event_e event_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    consumed_o = 1'b0;
    event_o    = EV_NONE;
    if (wr_valid_i) begin
      // fallback: restart on a lead write, else drop to idle
      state_d    = is_lead_i ? ST_P1 : ST_IDLE;
      consumed_o = is_lead_i;
      unique case (state_q)
        ST_P1: if (is_second_i) begin
          state_d = ST_P2; consumed_o = 1'b1;
        end
        ST_P2: if (at_lead_addr_i) begin
          if (data_i == BYTE_UNLOCK) begin
            state_d = ST_IDLE; consumed_o = 1'b1; event_o = EV_UNLOCK;
          end else if (data_i == BYTE_EXTEND) begin
            state_d = ST_X3; consumed_o = 1'b1;
          end else if (data_i == BYTE_ID_EXIT) begin
            state_d = ST_IDLE; consumed_o = 1'b1; event_o = EV_ID_EXIT;
          end
        end
        ST_X3: if (is_lead_i) begin
          state_d = ST_X4; consumed_o = 1'b1;
        end
        ST_X4: if (is_second_i) begin
          state_d = ST_X5; consumed_o = 1'b1;
        end
        ST_X5: if (at_lead_addr_i) begin
          if (data_i == BYTE_ERASE) begin
            state_d = ST_IDLE; consumed_o = 1'b1; event_o = EV_ERASE;
          end else if (data_i == BYTE_ID_ENTER) begin
            state_d = ST_IDLE; consumed_o = 1'b1; event_o = EV_ID_ENTER;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  AST_STRAY_TO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && !consumed_o) |=> (state_q == ST_IDLE)); // R10
  AST_LEAD_RESTARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && is_lead_i && state_q != ST_X3) |=> (state_q == ST_P1)); // R10
  AST_STATE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q inside {ST_IDLE, ST_P1, ST_P2, ST_X3, ST_X4, ST_X5}); // R10
endmodule

// File: rtl/cmd_mode_regs.sv
module cmd_mode_regs
  import cmd_seq_pkg::*;
#(
  parameter int   ADDR_W        = 17,
  parameter int   DATA_W        = 8,
  parameter int   LOAD_TIMEOUT  = 16,
  parameter logic PROT_AT_RESET = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic              consumed_i,
  input  seq_event_e        event_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              array_wr_o,
  output logic [ADDR_W-1:0] array_addr_o,
  output logic [DATA_W-1:0] array_data_o,
  output logic              write_rejected_o,
  output logic              erase_start_o,
  output logic              id_mode_o,
  output logic              prot_en_o,
  output logic              load_open_o
);
  localparam int CNT_W = $clog2(LOAD_TIMEOUT + 1);

  logic             data_wr, pass;
  logic [CNT_W-1:0] cnt_q;

  assign data_wr = wr_valid_i && !consumed_i;
  assign pass    = data_wr && (load_open_o || !prot_en_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prot_en_o        <= PROT_AT_RESET;
      id_mode_o        <= 1'b0;
      erase_start_o    <= 1'b0;
      array_wr_o       <= 1'b0;
      write_rejected_o <= 1'b0;
      array_addr_o     <= '0;
      array_data_o     <= '0;
    end else begin
      if (event_i == EV_UNLOCK) prot_en_o <= 1'b1;
      if (event_i == EV_ID_ENTER)     id_mode_o <= 1'b1;
      else if (event_i == EV_ID_EXIT) id_mode_o <= 1'b0;
      erase_start_o    <= (event_i == EV_ERASE);
      array_wr_o       <= pass;
      write_rejected_o <= data_wr && !pass;
      if (pass) begin
        array_addr_o <= wr_addr_i;
        array_data_o <= wr_data_i;
      end
    end
  end

  // load window: reloaded by unlock or an accepted write inside it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_open_o <= 1'b0;
      cnt_q       <= '0;
    end else if (event_i == EV_UNLOCK || (pass && load_open_o)) begin
      load_open_o <= 1'b1;
      cnt_q       <= CNT_W'(LOAD_TIMEOUT);
    end else if (load_open_o) begin
      cnt_q <= cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) load_open_o <= 1'b0;
    end
  end

  AST_WR_OR_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(array_wr_o && write_rejected_o)); // R5
  AST_PROT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_en_o |=> prot_en_o); // R3
  AST_ERASE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_start_o |=> !erase_start_o); // R6
  AST_WR_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr && prot_en_o && !load_open_o) |=> (!array_wr_o && write_rejected_o)); // R5
  AST_WINDOW_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_open_o |-> (cnt_q != '0)); // R4
  AST_CMD_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && consumed_i) |=> (!array_wr_o && !write_rejected_o)); // R3
endmodule

// File: rtl/cmd_id_mux.sv
module cmd_id_mux #(
  parameter int         ADDR_W   = 17,
  parameter logic [7:0] MFR_CODE = 8'hDA,
  parameter logic [7:0] DEV_CODE = 8'hC1
) (
  input  logic              id_mode_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [7:0]        array_rd_data_i,
  output logic [7:0]        rd_data_o
);
  logic upper_zero;
  assign upper_zero = (rd_addr_i[ADDR_W-1:1] == '0);

  always_comb begin
    rd_data_o = array_rd_data_i;
    if (id_mode_i && upper_zero)
      rd_data_o = rd_addr_i[0] ? DEV_CODE : MFR_CODE;
  end

  always_comb begin
    if (!id_mode_i)
      AST_PASS_THROUGH: assert (rd_data_o == array_rd_data_i); // R8
  end
endmodule

// File: rtl/cmd_seq_decoder.sv
module cmd_seq_decoder
  import cmd_seq_pkg::*;
#(
  parameter int   ADDR_W        = 17,
  parameter int   LOAD_TIMEOUT  = 16,
  parameter logic PROT_AT_RESET = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [7:0]        array_rd_data_i,
  output logic [7:0]        rd_data_o,
  output logic              array_wr_o,
  output logic [ADDR_W-1:0] array_addr_o,
  output logic [7:0]        array_data_o,
  output logic              write_rejected_o,
  output logic              erase_start_o,
  output logic              id_mode_o,
  output logic              prot_en_o,
  output logic              load_open_o
);
  logic       at_lead_addr, is_lead, is_second, consumed;
  seq_event_e seq_event;

  cmd_step_match u_match (
    .addr_i         (wr_addr_i[CMD_AW-1:0]),
    .data_i         (wr_data_i),
    .at_lead_addr_o (at_lead_addr),
    .is_lead_o      (is_lead),
    .is_second_o    (is_second)
  );

  cmd_seq_fsm u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .wr_valid_i     (wr_valid_i),
    .at_lead_addr_i (at_lead_addr),
    .is_lead_i      (is_lead),
    .is_second_i    (is_second),
    .data_i         (wr_data_i),
    .consumed_o     (consumed),
    .event_o        (seq_event)
  );

  cmd_mode_regs #(
    .ADDR_W        (ADDR_W),
    .DATA_W        (8),
    .LOAD_TIMEOUT  (LOAD_TIMEOUT),
    .PROT_AT_RESET (PROT_AT_RESET)
  ) u_regs (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .wr_valid_i       (wr_valid_i),
    .consumed_i       (consumed),
    .event_i          (seq_event),
    .wr_addr_i        (wr_addr_i),
    .wr_data_i        (wr_data_i),
    .array_wr_o       (array_wr_o),
    .array_addr_o     (array_addr_o),
    .array_data_o     (array_data_o),
    .write_rejected_o (write_rejected_o),
    .erase_start_o    (erase_start_o),
    .id_mode_o        (id_mode_o),
    .prot_en_o        (prot_en_o),
    .load_open_o      (load_open_o)
  );

  cmd_id_mux #(
    .ADDR_W (ADDR_W)
  ) u_id (
    .id_mode_i       (id_mode_o),
    .rd_addr_i       (rd_addr_i),
    .array_rd_data_i (array_rd_data_i),
    .rd_data_o       (rd_data_o)
  );

  AST_ID_ENTRY_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(id_mode_o) |-> $past(wr_valid_i && wr_data_i == BYTE_ID_ENTER)); // R7
  AST_ID_EXIT_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(id_mode_o) |-> $past(wr_valid_i && wr_data_i == BYTE_ID_EXIT)); // R9
endmodule

// File: tb/tb_cmd_seq_decoder.sv
module tb_cmd_seq_decoder;
  localparam int TO = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [16:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [16:0] rd_addr = '0;
  logic [7:0]  arr_rd = 8'h5A;
  logic [7:0]  rd_data;
  logic        array_wr, rej, erase, id_mode, prot_en, load_open;
  logic [16:0] array_addr;
  logic [7:0]  array_data;

  int n_chk = 0;
  int n_bad = 0;

  logic        s_wr, s_rej, s_er;
  logic [16:0] s_addr;
  logic [7:0]  s_data;

  always #4 clk = ~clk;

  cmd_seq_decoder #(.LOAD_TIMEOUT(TO)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wr_valid), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .array_rd_data_i(arr_rd),
    .rd_data_o(rd_data), .array_wr_o(array_wr), .array_addr_o(array_addr),
    .array_data_o(array_data), .write_rejected_o(rej), .erase_start_o(erase),
    .id_mode_o(id_mode), .prot_en_o(prot_en), .load_open_o(load_open)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge with outputs captured
  task automatic do_wr(input logic [16:0] a, input logic [7:0] d);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    s_wr = array_wr; s_rej = rej; s_er = erase; s_addr = array_addr; s_data = array_data;
    wr_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic rd_chk(input string req, input logic [16:0] a, input logic [7:0] exp);
    rd_addr = a; #1;
    chk(req, rd_data, exp);
  endtask

  task automatic t_reset;
    chk("R1 prot_en", prot_en, 1); chk("R1 id_mode", id_mode, 0);
    chk("R1 load_open", load_open, 0); chk("R1 array_wr", array_wr, 0);
    chk("R1 rejected", rej, 0); chk("R1 erase", erase, 0);
  endtask

  task automatic t_reject;
    do_wr(17'h00123, 8'h77);
    chk("R5 not forwarded", s_wr, 0); chk("R5 rejected", s_rej, 1);
    idle(1);
    chk("R5 pulse one cycle", rej, 0);
  endtask

  task automatic t_unlock_and_load;
    do_wr(17'h05555, 8'hAA);
    chk("R3 cmd not forwarded", s_wr, 0); chk("R3 cmd not rejected", s_rej, 0);
    do_wr(17'h02AAA, 8'h55);
    do_wr(17'h05555, 8'hA0);
    chk("R3 window open", load_open, 1); chk("R3 prot kept", prot_en, 1);
    idle(3);
    do_wr(17'h1A280, 8'h3C);
    chk("R4 forwarded", s_wr, 1); chk("R4 addr", s_addr, 17'h1A280);
    chk("R4 data", s_data, 8'h3C); chk("R4 no reject", s_rej, 0);
    idle(TO - 4);
    chk("R4 window restarted", load_open, 1);
    do_wr(17'h1A201, 8'hC3);
    chk("R4 second forwarded", s_wr, 1);
    idle(TO + 2);
    chk("R4 window closed", load_open, 0);
    do_wr(17'h1A202, 8'h11);
    chk("R4 after close rejected", s_rej, 1); chk("R4 after close not fwd", s_wr, 0);
  endtask

  task automatic t_erase;
    do_wr(17'h05555, 8'hAA); do_wr(17'h02AAA, 8'h55); do_wr(17'h05555, 8'h80);
    do_wr(17'h05555, 8'hAA); do_wr(17'h02AAA, 8'h55);
    chk("R6 no early erase", s_er, 0);
    do_wr(17'h05555, 8'h10);
    chk("R6 erase pulse", s_er, 1); chk("R6 no id change", id_mode, 0);
    idle(1);
    chk("R6 erase one cycle", erase, 0);
  endtask

  task automatic t_id;
    rd_chk("R8 normal mode addr0", 17'h00000, 8'h5A);
    do_wr(17'h05555, 8'hAA); do_wr(17'h02AAA, 8'h55); do_wr(17'h05555, 8'h80);
    do_wr(17'h05555, 8'hAA); do_wr(17'h02AAA, 8'h55); do_wr(17'h05555, 8'h60);
    chk("R7 id entered", id_mode, 1); chk("R7 no erase", s_er, 0);
    rd_chk("R8 mfr code", 17'h00000, 8'hDA);
    rd_chk("R8 dev code", 17'h00001, 8'hC1);
    rd_chk("R8 other addr", 17'h00002, 8'h5A);
    rd_chk("R8 high addr", 17'h10000, 8'h5A);
    do_wr(17'h05555, 8'hAA); do_wr(17'h02AAA, 8'h55); do_wr(17'h05555, 8'hF0);
    chk("R9 id exited", id_mode, 0);
    rd_chk("R9 addr0 back to array", 17'h00000, 8'h5A);
  endtask

  task automatic t_mismatch;
    // repeated lead restarts the sequence
    do_wr(17'h05555, 8'hAA); do_wr(17'h05555, 8'hAA);
    do_wr(17'h02AAA, 8'h55); do_wr(17'h05555, 8'hA0);
    chk("R10 restart unlocks", load_open, 1);
    idle(TO + 2);
    // stray write breaks the sequence
    do_wr(17'h05555, 8'hAA); do_wr(17'h02AAA, 8'h55);
    do_wr(17'h00100, 8'h12);
    chk("R10 stray rejected", s_rej, 1);
    do_wr(17'h05555, 8'hA0);
    chk("R10 late A0 rejected", s_rej, 1); chk("R10 no unlock", load_open, 0);
  endtask

  task automatic t_bad_tail;
    do_wr(17'h05555, 8'hAA); do_wr(17'h02AAA, 8'h55); do_wr(17'h05555, 8'h33);
    chk("R11 bad third byte rejected", s_rej, 1); chk("R11 bad third no open", load_open, 0);
    do_wr(17'h05555, 8'hAA); do_wr(17'h02AAA, 8'h55); do_wr(17'h05555, 8'h80);
    do_wr(17'h05555, 8'hAA); do_wr(17'h02AAA, 8'h55); do_wr(17'h05555, 8'h33);
    chk("R11 bad sixth no erase", s_er, 0); chk("R11 bad sixth rejected", s_rej, 1);
    chk("R11 bad sixth no id", id_mode, 0);
  endtask

  task automatic t_high_addr;
    do_wr(17'h15555, 8'hAA); do_wr(17'h0AAAA, 8'h55); do_wr(17'h1D555, 8'hA0);
    chk("R2 upper bits ignored", load_open, 1);
    idle(TO + 2);
    do_wr(17'h05554, 8'hAA);
    chk("R2 low bit compared", s_rej, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_reject();
    t_unlock_and_load();
    t_erase();
    t_id();
    t_mismatch();
    t_bad_tail();
    t_high_addr();
    idle(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule